// File: doc/BRIEF.md
# Latched 64-bit Free-Running Counter

This block keeps a 64-bit counter that advances on every clock cycle in which a tick enable is high. Software reaches the counter through a small register file on a 32-bit bus. A bus access can move only one 32-bit word, so software cannot read the full count in one access. To get a consistent value, software writes a snapshot command into the control register. That command copies the whole running count into a two-word hold register in a single cycle. Software can then read the two words at leisure, and the pair stays coherent.

A second command bit zeros the hold register. Both command bits clear themselves: they act on the cycle of the write and always read back as zero. The two hold words can also be written directly. The other control bits are plain storage. The time base that drives the tick enable lies outside this block.

Top module: `snap_counter64`

## Requirements
- R1: Address map. Address 0 is the control register, address 1 is the low hold word (count bits [31:0]) and address 2 is the high hold word (count bits [63:32]). Address 3 reads as zero, and a write to it changes nothing.
- R2: Control bits [31:2] store the written value and read it back unchanged. Control bits 1 and 0 always read as 0.
- R3: A control write with bit 1 (snapshot) set copies the running count into the hold words. The copied value is the count held in the cycle of the write, before any increment in that same cycle.
- R4: A control write with bit 0 (zero) set clears both hold words.
- R5: A control write with both bit 1 and bit 0 set leaves both hold words at zero.
- R6: The running count increases by exactly one in each cycle where `tick_en` is high, holds its value otherwise, and wraps from all ones to zero.
- R7: A write to address 1 or address 2 replaces only that hold word with the write data.
- R8: The hold words keep their value until the next snapshot, zero command or direct write. Reads and counter ticks do not change them.
- R9: After reset, the control register, both hold words and the running count are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Advances the running count by one in this cycle |
| bus_wr | input | 1 | Write strobe for the register at `bus_addr` |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |

## Verification
Two events can fall in the same cycle: a snapshot write and a counter increment. Per R3, the hold register must take the pre-increment count. The bench provokes this with directed snapshot writes made while `tick_en` is high, and with random traffic in which ticks and commands overlap freely. Each result is judged against a bench model that applies the command to the old count before it adds the tick. A second, narrow instance is run through a counter wrap, and the combined snapshot-plus-zero write is driven both directed and at random.

// File: rtl/snap_cnt_pkg.sv
package snap_cnt_pkg;
  localparam int LATCH_BIT  = 1;
  localparam int CLEAR_BIT  = 0;
  localparam int CTRL_ADDR  = 0;
  localparam int WORD0_ADDR = 1;
endpackage

// File: rtl/snap_cnt_run.sv
module snap_cnt_run #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [CNT_W-1:0] cnt_q
);
  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] v,
                                                input logic en);
    return en ? v + CNT_W'(1) : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= advance(cnt_q, tick_en);
  end
endmodule

// File: rtl/snap_cnt_ctrl.sv
module snap_cnt_ctrl
  import snap_cnt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              latch_evt,
  output logic              clear_evt
);
  function automatic logic [DATA_W-1:0] strip_cmds(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    r = v;
    r[LATCH_BIT] = 1'b0;
    r[CLEAR_BIT] = 1'b0;
    return r;
  endfunction

  assign latch_evt = ctrl_wr && wdata[LATCH_BIT];
  assign clear_evt = ctrl_wr && wdata[CLEAR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= strip_cmds(wdata);
  end
endmodule

// File: rtl/snap_cnt_hold.sv
module snap_cnt_hold #(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32,
  localparam int NWORDS = CNT_W / DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_evt,
  input  logic              clear_evt,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [NWORDS-1:0] word_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  snap_q
);
  // zero command wins over snapshot: snapshot first, then zero
  function automatic logic [DATA_W-1:0] next_word(input logic [DATA_W-1:0] cur,
                                                   input logic [DATA_W-1:0] live,
                                                   input logic [DATA_W-1:0] wd,
                                                   input logic lat, input logic clr,
                                                   input logic wr);
    if (clr)      return '0;
    else if (lat) return live;
    else if (wr)  return wd;
    else          return cur;
  endfunction

  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) snap_q[k*DATA_W +: DATA_W] <= '0;
      else        snap_q[k*DATA_W +: DATA_W] <=
                    next_word(snap_q[k*DATA_W +: DATA_W], cnt_q[k*DATA_W +: DATA_W],
                              wdata, latch_evt, clear_evt, word_wr[k]);
    end
  end
endmodule

// File: rtl/snap_counter64.sv
module snap_counter64
  import snap_cnt_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int NWORDS = CNT_W / DATA_W;

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  snap_q;
  logic [DATA_W-1:0] ctrl_q;
  logic              ctrl_wr;
  logic              latch_evt;
  logic              clear_evt;
  logic [NWORDS-1:0] word_wr;

  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));

  for (genvar k = 0; k < NWORDS; k++) begin : g_dec
    assign word_wr[k] = bus_wr && (bus_addr == ADDR_W'(WORD0_ADDR + k));
  end

  snap_cnt_run #(.CNT_W(CNT_W)) u_run (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_q(cnt_q)
  );

  snap_cnt_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wdata(bus_wdata),
    .ctrl_q(ctrl_q), .latch_evt(latch_evt), .clear_evt(clear_evt)
  );

  snap_cnt_hold #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .latch_evt(latch_evt), .clear_evt(clear_evt),
    .cnt_q(cnt_q), .word_wr(word_wr), .wdata(bus_wdata), .snap_q(snap_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(CTRL_ADDR)) bus_rdata = ctrl_q;
    for (int k = 0; k < NWORDS; k++) begin
      if (bus_addr == ADDR_W'(WORD0_ADDR + k)) bus_rdata = snap_q[k*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/snap_counter64_chk.sv
module snap_counter64_chk #(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32,
  localparam int NWORDS = CNT_W / DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              ctrl_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] ctrl_q,
  input logic              latch_evt,
  input logic              clear_evt,
  input logic [NWORDS-1:0] word_wr,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  snap_q
);
  p_ctrl_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (ctrl_q[DATA_W-1:2] == $past(bus_wdata[DATA_W-1:2])) && (ctrl_q[1:0] == 2'b00));

  p_snap_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_evt && !clear_evt) |=> snap_q == $past(cnt_q));

  p_snap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |=> snap_q == '0);

  p_both_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_evt && clear_evt) |=> snap_q == '0);

  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  p_count_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_q));

  p_snap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_evt && !clear_evt && (word_wr == '0)) |=> $stable(snap_q));

  p_one_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_wr, word_wr}));

  for (genvar k = 0; k < NWORDS; k++) begin : g_w
    p_word_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      word_wr[k] |=> snap_q[k*DATA_W +: DATA_W] == $past(bus_wdata));
  end
endmodule

bind snap_counter64 snap_counter64_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctrl_wr(ctrl_wr),
  .bus_wdata(bus_wdata), .ctrl_q(ctrl_q), .latch_evt(latch_evt),
  .clear_evt(clear_evt), .word_wr(word_wr), .cnt_q(cnt_q), .snap_q(snap_q)
);

// File: tb/snap_counter64_test.sv
module snap_counter64_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  logic        s_tick = 1'b0;
  logic        s_wr = 1'b0;
  logic [1:0]  s_addr = '0;
  logic [3:0]  s_wdata = '0;
  logic [3:0]  s_rdata;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [63:0] m_cnt = '0;
  logic [63:0] m_snap = '0;
  logic [31:0] m_ctrl = '0;
  logic [31:0] last_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  snap_counter64 uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  snap_counter64 #(.CNT_W(8), .DATA_W(4), .ADDR_W(2)) uut_small (
    .clk(clk), .rst_n(rst_n), .tick_en(s_tick), .bus_wr(s_wr),
    .bus_addr(s_addr), .bus_wdata(s_wdata), .bus_rdata(s_rdata)
  );

  function automatic logic [31:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return m_ctrl;
      2'd1:    return m_snap[31:0];
      2'd2:    return m_snap[63:32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock cycle: drive, sample read data, then apply the edge to the model
  task automatic step(input logic wr, input logic [1:0] a, input logic [31:0] d,
                      input logic tk);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; tick_en = tk;
    #1 last_rd = bus_rdata;
    @(posedge clk);
    if (wr) begin
      case (a)
        2'd0: begin
          m_ctrl = {d[31:2], 2'b00};
          if (d[1]) m_snap = m_cnt;
          if (d[0]) m_snap = '0;
        end
        2'd1: m_snap[31:0]  = d;
        2'd2: m_snap[63:32] = d;
        default: ;
      endcase
    end
    if (tk) m_cnt = m_cnt + 64'd1;
  endtask

  task automatic read_chk(input string tag, input logic [1:0] a, input logic tk);
    logic [31:0] e;
    e = exp_read(a);
    step(1'b0, a, 32'h0, tk);
    check(tag, {32'h0, last_rd}, {32'h0, e});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    // R9: reset values
    check("R9 ctrl", {32'h0, bus_rdata}, 64'h0);
    @(negedge clk); rst_n = 1'b1;
    read_chk("R9 low", 2'd1, 1'b0);
    read_chk("R9 high", 2'd2, 1'b0);
    read_chk("R9 ctrl", 2'd0, 1'b0);

    // R6 + R3: count 37 ticks, snapshot while ticking in the same cycle
    repeat (37) step(1'b0, 2'd3, 32'h0, 1'b1);
    step(1'b1, 2'd0, 32'h0000_0002, 1'b1);
    read_chk("R3 same-cycle low", 2'd1, 1'b0);
    check("R3 value", m_snap, 64'd37);
    read_chk("R3 high", 2'd2, 1'b0);
    read_chk("R2 cmd bits read 0", 2'd0, 1'b0);

    // R8: ticks do not disturb the hold words
    repeat (20) step(1'b0, 2'd1, 32'h0, 1'b1);
    read_chk("R8 hold low", 2'd1, 1'b1);

    // R2: upper control bits stored
    step(1'b1, 2'd0, 32'hA5A5_F00C, 1'b0);
    read_chk("R2 ctrl readback", 2'd0, 1'b0);

    // R7: direct writes touch only their word
    step(1'b1, 2'd2, 32'hDEAD_BEEF, 1'b0);
    read_chk("R7 high written", 2'd2, 1'b0);
    read_chk("R7 low untouched", 2'd1, 1'b0);
    step(1'b1, 2'd1, 32'h1234_5678, 1'b1);
    read_chk("R7 low written", 2'd1, 1'b0);
    read_chk("R7 high untouched", 2'd2, 1'b0);

    // R1: address 3 reads zero, write ignored
    step(1'b1, 2'd3, 32'hFFFF_FFFF, 1'b0);
    read_chk("R1 addr3 zero", 2'd3, 1'b0);
    read_chk("R1 ctrl unchanged", 2'd0, 1'b0);
    read_chk("R1 low unchanged", 2'd1, 1'b0);

    // R4: zero command
    step(1'b1, 2'd0, 32'h0000_0001, 1'b1);
    read_chk("R4 low zero", 2'd1, 1'b0);
    read_chk("R4 high zero", 2'd2, 1'b0);

    // R5: both commands in one write
    step(1'b1, 2'd2, 32'h0000_0099, 1'b0);
    step(1'b1, 2'd0, 32'h0000_0003, 1'b1);
    read_chk("R5 low zero", 2'd1, 1'b0);
    read_chk("R5 high zero", 2'd2, 1'b0);
    read_chk("R5 ctrl", 2'd0, 1'b0);

    // random mix of ticks, commands, direct writes and reads
    for (int i = 0; i < 3000; i++) begin
      int unsigned op;
      logic [31:0] d;
      op = $urandom_range(0, 9);
      d = $urandom();
      if (op < 4) begin
        logic [1:0] a;
        a = 2'($urandom_range(0, 3));
        read_chk(a == 2'd3 ? "R1 rand" : (a == 2'd0 ? "R2 rand" : "R8 rand"),
                 a, 1'($urandom_range(0, 1)));
      end else if (op < 7) begin
        step(1'b1, 2'd0, d, 1'($urandom_range(0, 1)));
      end else begin
        step(1'b1, 2'($urandom_range(1, 3)), d, 1'($urandom_range(0, 1)));
      end
    end

    // R6 wrap on the narrow instance: 300 ticks -> 300 mod 256 = 44 = 8'h2C
    @(negedge clk); s_tick = 1'b1;
    repeat (300) @(negedge clk);
    s_tick = 1'b0; s_wr = 1'b1; s_addr = 2'd0; s_wdata = 4'h2;
    @(negedge clk); s_wr = 1'b0; s_addr = 2'd1;
    #1 check("R6 wrap low", {60'h0, s_rdata}, 64'hC);
    s_addr = 2'd2;
    #1 check("R6 wrap high", {60'h0, s_rdata}, 64'h2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule